// File: doc/BRIEF.md
# Synthesizer control-byte mode decoder

This block sits behind the serial front end of a frequency synthesizer. Each time a control byte lands, it receives a single-cycle strobe that carries two fields: a 3-bit mode code and a 3-bit reference-select code. From the mode code it drives four things: the source of the clock output pin, the charge-pump override lines, the tuning-voltage enable, and a loop-bandwidth-control enable. One mode code does not select a static state. Each write of that code flips the bandwidth-control enable. To flip the enable and then settle in a different mode, software sends two control bytes in a row.

The block also watches the reference-select code. When a control byte changes it, the divider ratio is no longer valid. A pending flag then stays raised until both divider data bytes (low and high) have been written again, in either order. The crystal, half-divided and comparison clocks arrive as inputs that are synchronous to the system clock. The output clock is a registered copy of the selected source. A change of source waits until the output is low, so no shortened pulse reaches the pin.

Two small state machines carry the sequencing. The resend tracker has four states:
- `RS_IDLE`: nothing owed.
- `RS_NEED_BOTH`: a reference change was seen.
- `RS_NEED_LO`: the high byte has arrived.
- `RS_NEED_HI`: the low byte has arrived.

A reference change moves the tracker from any state to `RS_NEED_BOTH`. From there, a data byte moves it to `RS_NEED_LO` or `RS_NEED_HI`, depending on which byte arrived. The missing byte then returns it to `RS_IDLE`.

The source switcher has two states:
- `SW_STEADY`: the active source matches the requested one.
- `SW_HOLD`: a new source has been requested.

A mismatch between the requested and active source moves the switcher from `SW_STEADY` to `SW_HOLD`. In `SW_HOLD`, the first cycle with the output low adopts the new source and returns to `SW_STEADY`.

Top module: `synth_mode_decoder`

## Requirements
- R1: After reset, the mode is 110, the output carries the crystal clock, the bandwidth enable is 0, `cp_sink` is 1, `vtune_en` is 0 and `resend_pending` is 0.
- R2: The output source follows the mode once settled: 000 and 111 give a constant 0; 001, 011 and 110 give the crystal clock; 010 and 101 give the half-divided clock; 100 gives the comparison clock. The output is the selected source delayed by one clock.
- R3: Every control write with mode 011 inverts `albc_en`. Any other control write, and any cycle without a control write, leaves it unchanged.
- R4: `cp_off` is 1 only in mode 010, `cp_sink` only in mode 110 and `cp_source` only in mode 111.
- R5: `vtune_en` is 0 in mode 110 and 1 in every other mode.
- R6: A control write whose reference-select code differs from the stored code sets `resend_pending` in the next cycle. A control write with the same code leaves the pending state as it was.
- R7: While pending, `resend_pending` clears only after data writes with `db_hi`=0 and `db_hi`=1 have both been seen, in either order. A repeated write of the same byte does not clear it. Data writes while not pending have no effect.
- R8: The active output source changes only in a cycle that follows an output value of 0.
- R9: Rewriting the current non-toggle mode changes none of the outputs, and the output clock keeps running without a break.
- R10: Mode, bandwidth enable and pending state change only on the clock edge that samples a write strobe. The outputs decoded from them are valid right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Single-cycle control byte strobe |
| ctrl_mode | input | 3 | Mode code carried by the control byte |
| ctrl_ref | input | REF_W | Reference-select code carried by the control byte |
| data_wr | input | 1 | Single-cycle divider data byte strobe |
| db_hi | input | 1 | 1 = high divider byte, 0 = low divider byte |
| xtal_in | input | 1 | Crystal reference clock, sampled |
| half_div_in | input | 1 | Half of the divided oscillator clock, sampled |
| comp_in | input | 1 | Comparison clock, sampled |
| clk_out | output | 1 | Registered selected clock for the output pin |
| cp_off | output | 1 | Charge pump disabled |
| cp_sink | output | 1 | Charge pump forced to sink |
| cp_source | output | 1 | Charge pump forced to source |
| vtune_en | output | 1 | Tuning voltage enabled |
| albc_en | output | 1 | Automatic loop-bandwidth control enabled |
| resend_pending | output | 1 | Divider data bytes must be rewritten |

## Verification
The assertions assume three things about the inputs:
- `ctrl_wr` and `data_wr` never rise in the same cycle.
- The mode and reference fields are defined whenever the control strobe is high.
- The clock sources change only between system clock edges.

The stimulus meets these assumptions. It drives only one kind of strobe per operation and draws both fields from `$urandom` while the strobe is up. It updates the source clocks a fixed time after each rising edge, from one counter. The random reference codes come from a narrow range, so that same-code rewrites occur often. Directed cases cover the double toggle, same-mode rewrites, and duplicate data bytes while pending.

// File: rtl/smd_pkg.sv
package smd_pkg;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_HALF = 2'd2,
        SRC_COMP = 2'd3
    } src_t;

    typedef enum logic [1:0] {
        RS_IDLE      = 2'd0,
        RS_NEED_BOTH = 2'd1,
        RS_NEED_LO   = 2'd2,
        RS_NEED_HI   = 2'd3
    } rs_state_t;

    typedef enum logic {
        SW_STEADY = 1'b0,
        SW_HOLD   = 1'b1
    } sw_state_t;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 3'b011;
    localparam logic [MODE_W-1:0] MODE_RESET  = 3'b110;

endpackage

// File: rtl/smd_ctrl_regs.sv
module smd_ctrl_regs
    import smd_pkg::*;
#(
    parameter int REF_W = 3,
    parameter logic [REF_W-1:0] REF_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [MODE_W-1:0] ctrl_mode,
    input  logic [REF_W-1:0]  ctrl_ref,
    output logic [MODE_W-1:0] mode_q,
    output logic [REF_W-1:0]  ref_q,
    output logic              albc_q,
    output logic              ref_change
);

    assign ref_change = ctrl_wr && (ctrl_ref != ref_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
            ref_q  <= REF_INIT;
            albc_q <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q <= ctrl_mode;
            ref_q  <= ctrl_ref;
            if (ctrl_mode == MODE_TOGGLE) begin
                albc_q <= ~albc_q;
            end
        end
    end

endmodule

// File: rtl/smd_resend_fsm.sv
module smd_resend_fsm
    import smd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_change,
    input  logic      data_wr,
    input  logic      db_hi,
    output logic      pending,
    output rs_state_t state
);

    rs_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (ref_change) begin
            nxt = RS_NEED_BOTH;
        end else begin
            unique case (state)
                RS_IDLE:      nxt = RS_IDLE;
                RS_NEED_BOTH: if (data_wr) nxt = db_hi ? RS_NEED_LO : RS_NEED_HI;
                RS_NEED_LO:   if (data_wr && !db_hi) nxt = RS_IDLE;
                RS_NEED_HI:   if (data_wr && db_hi)  nxt = RS_IDLE;
            endcase
        end
    end

    always_comb begin
        pending = (state != RS_IDLE);
    end

endmodule

// File: rtl/smd_clk_switch.sv
module smd_clk_switch
    import smd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  src_t      req_src,
    input  logic      xtal_in,
    input  logic      half_div_in,
    input  logic      comp_in,
    output src_t      act_src,
    output logic      clk_out,
    output sw_state_t state
);

    sw_state_t nxt;
    logic      picked;

    always_comb begin
        nxt = state;
        unique case (state)
            SW_STEADY: if (req_src != act_src) nxt = SW_HOLD;
            SW_HOLD:   if (!clk_out)           nxt = SW_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SW_STEADY;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_src <= SRC_XTAL;
        end else if (state == SW_HOLD && !clk_out) begin
            act_src <= req_src;
        end
    end

    always_comb begin
        unique case (act_src)
            SRC_OFF:  picked = 1'b0;
            SRC_XTAL: picked = xtal_in;
            SRC_HALF: picked = half_div_in;
            SRC_COMP: picked = comp_in;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_out <= 1'b0;
        else        clk_out <= picked;
    end

endmodule

// File: rtl/synth_mode_decoder.sv
module synth_mode_decoder
    import smd_pkg::*;
#(
    parameter int REF_W = 3,
    parameter logic [REF_W-1:0] REF_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [2:0]       ctrl_mode,
    input  logic [REF_W-1:0] ctrl_ref,
    input  logic             data_wr,
    input  logic             db_hi,
    input  logic             xtal_in,
    input  logic             half_div_in,
    input  logic             comp_in,
    output logic             clk_out,
    output logic             cp_off,
    output logic             cp_sink,
    output logic             cp_source,
    output logic             vtune_en,
    output logic             albc_en,
    output logic             resend_pending
);

    logic [MODE_W-1:0] mode_q;
    logic [REF_W-1:0]  ref_q;
    logic              ref_change;
    src_t              req_src;
    src_t              act_src;
    rs_state_t         rs_state;
    sw_state_t         sw_state;

    smd_ctrl_regs #(.REF_W(REF_W), .REF_INIT(REF_INIT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_mode  (ctrl_mode),
        .ctrl_ref   (ctrl_ref),
        .mode_q     (mode_q),
        .ref_q      (ref_q),
        .albc_q     (albc_en),
        .ref_change (ref_change)
    );

    smd_resend_fsm u_resend (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_change (ref_change),
        .data_wr    (data_wr),
        .db_hi      (db_hi),
        .pending    (resend_pending),
        .state      (rs_state)
    );

    always_comb begin
        req_src   = SRC_OFF;
        cp_off    = 1'b0;
        cp_sink   = 1'b0;
        cp_source = 1'b0;
        vtune_en  = 1'b1;
        unique case (mode_q)
            3'b000: req_src = SRC_OFF;
            3'b001: req_src = SRC_XTAL;
            3'b010: begin req_src = SRC_HALF; cp_off = 1'b1; end
            3'b011: req_src = SRC_XTAL;
            3'b100: req_src = SRC_COMP;
            3'b101: req_src = SRC_HALF;
            3'b110: begin req_src = SRC_XTAL; cp_sink = 1'b1; vtune_en = 1'b0; end
            3'b111: begin req_src = SRC_OFF; cp_source = 1'b1; end
        endcase
    end

    smd_clk_switch u_switch (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_src     (req_src),
        .xtal_in     (xtal_in),
        .half_div_in (half_div_in),
        .comp_in     (comp_in),
        .act_src     (act_src),
        .clk_out     (clk_out),
        .state       (sw_state)
    );

endmodule

// File: rtl/smd_checker.sv
module smd_checker #(
    parameter int REF_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic [2:0]       ctrl_mode,
    input logic [REF_W-1:0] ctrl_ref,
    input logic [REF_W-1:0] ref_q,
    input logic [2:0]       mode_q,
    input logic             data_wr,
    input logic [1:0]       act_src,
    input logic             clk_out,
    input logic             cp_sink,
    input logic             vtune_en,
    input logic             albc_en,
    input logic             resend_pending
);

    AST_ALBC_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_mode == 3'b011) |=> (albc_en != $past(albc_en))); // R3

    AST_ALBC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && ctrl_mode == 3'b011) |=> $stable(albc_en)); // R3

    AST_VTUNE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        !vtune_en |-> cp_sink); // R5

    AST_PEND_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_ref != ref_q) |=> resend_pending); // R6

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (resend_pending && !data_wr) |=> resend_pending); // R7

    AST_SWITCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_src) |-> !$past(clk_out)); // R8

    AST_MODE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(mode_q)); // R10

endmodule

bind synth_mode_decoder smd_checker #(.REF_W(REF_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_wr        (ctrl_wr),
    .ctrl_mode      (ctrl_mode),
    .ctrl_ref       (ctrl_ref),
    .ref_q          (ref_q),
    .mode_q         (mode_q),
    .data_wr        (data_wr),
    .act_src        (act_src),
    .clk_out        (clk_out),
    .cp_sink        (cp_sink),
    .vtune_en       (vtune_en),
    .albc_en        (albc_en),
    .resend_pending (resend_pending)
);

// File: tb/synth_mode_decoder_test.sv
`timescale 1ns/1ps
module synth_mode_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [2:0] ctrl_mode = 3'b0;
    logic [2:0] ctrl_ref = 3'b0;
    logic       data_wr = 1'b0;
    logic       db_hi = 1'b0;
    logic       xtal_in = 1'b0;
    logic       half_div_in = 1'b0;
    logic       comp_in = 1'b0;
    logic       clk_out, cp_off, cp_sink, cp_source, vtune_en, albc_en, resend_pending;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;
    logic p_xtal = 1'b0, p_half = 1'b0, p_comp = 1'b0;

    logic [2:0] e_mode = 3'b110;
    logic [2:0] e_ref = 3'b000;
    logic       e_albc = 1'b0;
    logic       e_pend = 1'b0;
    logic       got_lo = 1'b0, got_hi = 1'b0;

    always #4 clk = ~clk;

    synth_mode_decoder uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_mode(ctrl_mode),
        .ctrl_ref(ctrl_ref), .data_wr(data_wr), .db_hi(db_hi),
        .xtal_in(xtal_in), .half_div_in(half_div_in), .comp_in(comp_in),
        .clk_out(clk_out), .cp_off(cp_off), .cp_sink(cp_sink),
        .cp_source(cp_source), .vtune_en(vtune_en), .albc_en(albc_en),
        .resend_pending(resend_pending)
    );

    // source clocks: updated 2 ns after each rising edge, previous values kept
    initial begin
        forever begin
            @(posedge clk);
            #2;
            p_xtal = xtal_in; p_half = half_div_in; p_comp = comp_in;
            cyc++;
            xtal_in     = cyc[0];
            half_div_in = ((cyc / 3) % 2) == 1;
            comp_in     = (cyc % 5) == 0;
        end
    end

    function automatic logic exp_out(input logic [2:0] m);
        case (m)
            3'b001, 3'b011, 3'b110: return p_xtal;
            3'b010, 3'b101:         return p_half;
            3'b100:                 return p_comp;
            default:                return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_static(input string tag);
        check({tag, " R4 cp"}, {5'b0, cp_off, cp_sink, cp_source},
              {5'b0, e_mode == 3'b010, e_mode == 3'b110, e_mode == 3'b111});
        check({tag, " R5 vtune"}, {7'b0, vtune_en}, {7'b0, e_mode != 3'b110});
        check({tag, " R3 albc"}, {7'b0, albc_en}, {7'b0, e_albc});
        check({tag, " R7 pending"}, {7'b0, resend_pending}, {7'b0, e_pend});
    endtask

    task automatic check_clock(input string tag, input int settle, input int n);
        for (int i = 0; i < settle; i++) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({tag, " R2 clk_out"}, {7'b0, clk_out}, {7'b0, exp_out(e_mode)});
        end
    endtask

    task automatic wr_ctrl(input logic [2:0] m, input logic [2:0] r);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_mode = m; ctrl_ref = r;
        @(negedge clk);
        ctrl_wr = 1'b0;
        if (m == 3'b011) e_albc = ~e_albc;
        if (r != e_ref) begin e_pend = 1'b1; got_lo = 1'b0; got_hi = 1'b0; end
        e_mode = m; e_ref = r;
    endtask

    task automatic wr_data(input logic hi);
        @(negedge clk);
        data_wr = 1'b1; db_hi = hi;
        @(negedge clk);
        data_wr = 1'b0;
        if (e_pend) begin
            if (hi) got_hi = 1'b1; else got_lo = 1'b1;
            if (got_hi && got_lo) e_pend = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_static("R1 reset");
        check_clock("R1 reset", 4, 6);

        // R3 double toggle, then chosen mode
        wr_ctrl(3'b011, 3'b000); check_static("R3 t1");
        wr_ctrl(3'b011, 3'b000); check_static("R3 t2");
        wr_ctrl(3'b100, 3'b000); check_static("R3 after");
        check_clock("R2 comp", 8, 10);

        // R9 same mode rewrite: clock keeps running
        wr_ctrl(3'b001, 3'b000); check_clock("R9 pre", 8, 2);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_mode = 3'b001; ctrl_ref = 3'b000;
        check({"R9 during"}, {7'b0, clk_out}, {7'b0, exp_out(e_mode)});
        @(negedge clk); ctrl_wr = 1'b0;
        check({"R9 after"}, {7'b0, clk_out}, {7'b0, exp_out(e_mode)});
        check_static("R9");

        // R6/R7 duplicate byte does not clear
        wr_ctrl(3'b000, 3'b101); check_static("R6 raise");
        wr_data(1'b1); check_static("R7 hi");
        wr_data(1'b1); check_static("R7 dup");
        wr_data(1'b0); check_static("R7 clear");
        wr_data(1'b0); check_static("R7 idle");
        wr_ctrl(3'b000, 3'b101); check_static("R6 same ref");
        check_clock("R2 off", 8, 4);

        // constrained random
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 3) != 0) begin
                wr_ctrl(3'($urandom % 8), 3'($urandom % 2));
                check_static("R10 rnd ctrl");
                if (($urandom % 4) == 0) check_clock("rnd", 8, 4);
            end else begin
                wr_data(1'($urandom % 2));
                check_static("R7 rnd data");
            end
        end

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule